// File: doc/BRIEF.md
# GF(2^89) Quadratic Equation Solver

This block takes a field element `a` from GF(2^89) and returns an element `z` with z^2 + z = a. Field elements are 89-bit vectors: bit i is the coefficient of u^i, and arithmetic is reduced by the trinomial u^89 + u^38 + 1. Alongside the root, the block raises a flag when the equation has a root at all. A root exists exactly when the absolute trace of `a` is zero.

Point-halving datapaths use this solver. They need one root of the quadratic, and they choose between the two roots themselves. The two roots differ by the constant 1. The solver always returns the root whose constant coefficient is zero. The caller gets the other root by inverting bit 0.

The arithmetic is a linear network built only from XOR gates. By default one register stage sits at the output, so a result appears one clock after its input. A parameter removes that register and leaves a purely combinational path.

Top module: `gf89_qsolve`

## Requirements
- R1: When the trace of `a_in` is 0, `z_out` satisfies z^2 + z = a. Squaring is reduced with u^89 = u^38 + 1, and bit i holds the coefficient of u^i.
- R2: Bit 0 of `z_out` is always 0. The block returns the root with zero constant term.
- R3: `solvable` is 1 exactly when Tr(a) = 0. Here Tr(a) is bit 0 of the sum of a^(2^k) for k = 0 to 88; that sum is always 0 or 1.
- R4: When Tr(a) = 1, `solvable` is 0, and `z_out` is a fixed function of `a` that satisfies z^2 + z = a + 1.
- R5: With the default output register, both outputs show the result for the `a_in` sampled at the previous rising clock edge. A change on `a_in` between edges does not reach the outputs.
- R6: While `rst_n` is low, `z_out` is all zeros and `solvable` is 0. Reset takes effect asynchronously.
- R7: An all-zero input gives `z_out` = 0 and `solvable` = 1.
- R8: The input a = 1 (only bit 0 set) has trace 1. It gives `solvable` = 0 and `z_out` = 0.
- R9: For inputs a and b that both have trace 0, the output for a XOR b equals the XOR of the outputs for a and for b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | 89 | Right-hand side `a`; bit i is the coefficient of u^i |
| z_out | output | 89 | Root `z` with bit 0 equal to 0 |
| solvable | output | 1 | High when Tr(a) = 0, meaning `z_out` is a true root |

## Verification
The checker assumes that `a_in` carries defined values at every rising edge once reset is released. It also assumes that the registered results line up with the input captured at that same edge, which its own one-deep copy of `a_in` tracks. Its properties are disabled while reset is low and for the first edge after release, because no captured input exists yet. The stimulus changes `a_in` and `rst_n` only on falling edges, with one exception: a single mid-cycle reset pulse, which exercises the asynchronous clear and falls inside the disabled window.

// File: rtl/gf89_pkg.sv
package gf89_pkg;
  // field GF(2)[u] / (u^FDEG + u^FTAP + 1)
  localparam int FDEG = 89;
  localparam int FTAP = 38;
  localparam int WIDE = 2 * FDEG - 1;
  localparam int HALF_STAGES = (FDEG - 1) / 2;

  typedef logic [FDEG-1:0] gf_t;

  // square: spread the bits to even positions, then fold the high part back
  function automatic gf_t gf_sqr(input gf_t x);
    logic [WIDE-1:0] w;
    w = '0;
    for (int i = 0; i < FDEG; i++) w[2*i] = x[i];
    for (int j = WIDE - 1; j >= FDEG; j--) begin
      if (w[j]) begin
        w[j]              = 1'b0;
        w[j-FDEG]         = ~w[j-FDEG];
        w[j-FDEG+FTAP]    = ~w[j-FDEG+FTAP];
      end
    end
    return w[FDEG-1:0];
  endfunction

  // coefficient set whose parity equals the absolute trace
  function automatic gf_t gf_trace_mask();
    gf_t m;
    gf_t p;
    gf_t acc;
    m = '0;
    for (int i = 0; i < FDEG; i++) begin
      p    = '0;
      p[i] = 1'b1;
      acc  = '0;
      for (int k = 0; k < FDEG; k++) begin
        acc = acc ^ p;
        p   = gf_sqr(p);
      end
      m[i] = acc[0];
    end
    return m;
  endfunction
endpackage

// File: rtl/gf89_square.sv
module gf89_square
  import gf89_pkg::*;
(
  input  gf_t x,
  output gf_t y
);
  assign y = gf_sqr(x);
endmodule

// File: rtl/gf89_halftrace.sv
module gf89_halftrace
  import gf89_pkg::*;
#(
  parameter int STAGES = HALF_STAGES
) (
  input  gf_t a,
  output gf_t h
);
  // h = sum over i of a^(4^i), i = 0..STAGES
  gf_t pw  [STAGES+1];
  gf_t acc [STAGES+1];

  assign pw[0]  = a;
  assign acc[0] = a;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    gf_t sq_mid;
    gf89_square u_sq_a (.x(pw[s]),  .y(sq_mid));
    gf89_square u_sq_b (.x(sq_mid), .y(pw[s+1]));
    assign acc[s+1] = acc[s] ^ pw[s+1];
  end

  assign h = acc[STAGES];
endmodule

// File: rtl/gf89_trace.sv
module gf89_trace
  import gf89_pkg::*;
(
  input  gf_t  a,
  output logic tr
);
  localparam gf_t TMASK = gf_trace_mask();
  assign tr = ^(a & TMASK);
endmodule

// File: rtl/gf89_qsolve.sv
module gf89_qsolve
  import gf89_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FDEG-1:0] a_in,
  output logic [FDEG-1:0] z_out,
  output logic            solvable
);
  gf_t  half_trace;
  logic trace_bit;
  gf_t  z_next;

  gf89_halftrace u_ht (.a(a_in), .h(half_trace));
  gf89_trace     u_tr (.a(a_in), .tr(trace_bit));

  // the two roots differ by 1; keep the one with zero constant term
  assign z_next = {half_trace[FDEG-1:1], 1'b0};

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        z_out    <= '0;
        solvable <= 1'b0;
      end else begin
        z_out    <= z_next;
        solvable <= ~trace_bit;
      end
    end
  end else begin : g_comb
    assign z_out    = z_next;
    assign solvable = ~trace_bit;
  end
endmodule

// File: rtl/gf89_qsolve_chk.sv
module gf89_qsolve_chk
  import gf89_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input gf_t  a_in,
  input gf_t  z_out,
  input logic solvable,
  input logic trace_bit,
  input gf_t  half_trace
);
  gf_t  a_seen;
  logic tr_seen;
  logic primed;
  gf_t  zz;
  gf_t  one_v;

  assign one_v = gf_t'(1);
  assign zz    = gf_sqr(z_out) ^ z_out;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_seen  <= '0;
        tr_seen <= 1'b0;
        primed  <= 1'b0;
      end else begin
        a_seen  <= a_in;
        tr_seen <= trace_bit;
        primed  <= 1'b1;
      end
    end

    always @(negedge clk) begin
      if (!rst_n) begin
        AST_RESET_CLEAR: assert (z_out == '0 && !solvable) else $error("outputs not cleared in reset"); // R6
      end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $stable(a_in)) |=> ($stable(z_out) && $stable(solvable))); // R5
  end else begin : g_comb
    assign a_seen  = a_in;
    assign tr_seen = trace_bit;
    assign primed  = 1'b1;
  end

  AST_ROOT_EQN: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && solvable) |-> (zz == a_seen)); // R1

  AST_ROOT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (z_out[0] == 1'b0)); // R2

  AST_FLAG_TRACE: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (solvable == ~tr_seen)); // R3

  AST_NOSOL_EQN: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !solvable) |-> (zz == (a_seen ^ one_v))); // R4

  AST_HALFTRACE_ID: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> ((gf_sqr(half_trace) ^ half_trace) == (a_in ^ gf_t'(trace_bit)))); // R4

  AST_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && a_seen == '0) |-> (z_out == '0 && solvable)); // R7
endmodule

bind gf89_qsolve gf89_qsolve_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .a_in(a_in),
  .z_out(z_out),
  .solvable(solvable),
  .trace_bit(trace_bit),
  .half_trace(half_trace)
);

// File: tb/gf89_qsolve_test.sv
module gf89_qsolve_test;
  localparam int M = 89;
  localparam int TAP = 38;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic [M-1:0] a = '0;
  logic [M-1:0] z;
  logic         sol;
  int           checks = 0;
  int           errors = 0;
  logic [M-1:0] last_z = '0;
  bit           have_last = 1'b0;

  always #4 clk = ~clk;

  gf89_qsolve uut (.clk(clk), .rst_n(rst_n), .a_in(a), .z_out(z), .solvable(sol));

  // multiply by u, folding u^M back as u^TAP + 1
  function automatic logic [M-1:0] times_u(input logic [M-1:0] p);
    logic hi;
    hi = p[M-1];
    p  = p << 1;
    if (hi) begin
      p[0]   = ~p[0];
      p[TAP] = ~p[TAP];
    end
    return p;
  endfunction

  function automatic logic [M-1:0] ref_sq(input logic [M-1:0] x);
    logic [M-1:0] acc;
    logic [M-1:0] pw;
    acc = '0;
    pw  = {{(M-1){1'b0}}, 1'b1};
    for (int i = 0; i < M; i++) begin
      if (x[i]) acc = acc ^ pw;
      pw = times_u(times_u(pw));
    end
    return acc;
  endfunction

  function automatic logic ref_trace(input logic [M-1:0] x);
    logic [M-1:0] acc;
    logic [M-1:0] p;
    acc = '0;
    p   = x;
    for (int k = 0; k < M; k++) begin
      acc = acc ^ p;
      p   = ref_sq(p);
    end
    return acc[0];
  endfunction

  function automatic logic [M-1:0] rnd();
    logic [95:0] r;
    r = {$urandom, $urandom, $urandom};
    return r[M-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; leaves time at the next falling edge
  task automatic apply(input logic [M-1:0] v, output logic [M-1:0] zr);
    logic [M-1:0] one;
    logic tr;
    one = {{(M-1){1'b0}}, 1'b1};
    a = v;
    #1;
    if (have_last) check(z == last_z, "R5 no change before edge", z, last_z);
    @(negedge clk);
    tr = ref_trace(v);
    check(sol == !tr, "R3 flag", M'(sol), M'(!tr));
    if (!tr) check((ref_sq(z) ^ z) == v, "R1 root equation", ref_sq(z) ^ z, v);
    else     check((ref_sq(z) ^ z) == (v ^ one), "R4 no-root equation", ref_sq(z) ^ z, v ^ one);
    check(z[0] == 1'b0, "R2 zero constant term", M'(z[0]), '0);
    zr        = z;
    last_z    = z;
    have_last = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [M-1:0] zr, za, zb, w, va, vb, exp_z;
    #1 rst_n = 1'b0;
    a = rnd();
    @(negedge clk);
    @(negedge clk);
    check(z == '0, "R6 reset root", z, '0);
    check(sol == 1'b0, "R6 reset flag", M'(sol), '0);
    rst_n = 1'b1;

    // R7: zero input
    apply('0, zr);
    check(zr == '0 && sol == 1'b1, "R7 zero input", zr, '0);

    // R8: a = 1
    apply({{(M-1){1'b0}}, 1'b1}, zr);
    check(zr == '0 && sol == 1'b0, "R8 unit input", {zr[M-2:0], sol}, '0);

    // single-term inputs u^i
    for (int i = 0; i < M; i++) begin
      logic [M-1:0] v;
      v = '0;
      v[i] = 1'b1;
      apply(v, zr);
    end

    apply({M{1'b1}}, zr);

    // R1: inputs built as w^2 + w must give exactly w or w+1
    for (int n = 0; n < 60; n++) begin
      w = rnd();
      exp_z = w;
      exp_z[0] = 1'b0;
      apply(ref_sq(w) ^ w, zr);
      check(zr == exp_z && sol, "R1 exact root", zr, exp_z);
    end

    // arbitrary inputs, both traces
    for (int n = 0; n < 60; n++) apply(rnd(), zr);

    // R9: additivity over solvable inputs
    for (int n = 0; n < 20; n++) begin
      w  = rnd();
      va = ref_sq(w) ^ w;
      w  = rnd();
      vb = ref_sq(w) ^ w;
      apply(va, za);
      apply(vb, zb);
      apply(va ^ vb, zr);
      check(zr == (za ^ zb), "R9 additivity", zr, za ^ zb);
    end

    // R6: asynchronous reset in mid cycle
    apply(rnd() | {{(M-1){1'b0}}, 1'b0} | (M'(1) << 5), zr);
    #2 rst_n = 1'b0;
    #1;
    check(z == '0 && sol == 1'b0, "R6 async clear", {z[M-2:0], sol}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    have_last = 1'b0;
    apply('0, zr);
    check(zr == '0 && sol == 1'b1, "R7 zero after reset", zr, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule